// File: doc/BRIEF.md
# LCD Segment Line Data Driver

This block loads one display line of segment data and turns it into per-column drive-level codes for a dot-matrix passive LCD. Two strobes control the loading. Each falling edge of the capture strobe writes one parallel bus word into a first-stage line buffer. The slot for that word comes from a one-hot capture pointer. A falling edge of the line strobe then copies the whole buffer into a second-stage output register. The same edge rewinds the pointer for the next line. Each of the 320 columns is then encoded as a 2-bit level code from its data bit, the AC phase input and the display-off control.

Several drivers can share one bus in a chain. The low-active enable token enters on one side of a chip. The chip captures only while that token is active. When its buffer is full, it drives the token out on the other side so the next chip starts capturing. The reverse-order control mirrors the column order end to end and swaps which chain side is input and which is output. A reduced mode uses only the middle 240 columns. Both strobes are sampled and edge-detected in the single system clock domain.

The data flow is paced by the strobes. There is no valid/ready pair and no back-pressure. A bus word is taken on each detected capture edge while the token is active and the buffer is not full, and is otherwise dropped.

Top module: `lcd_seg_line_drv`

## Requirements
- R1: After reset the output register is all zero, the capture pointer is at slot 0, and both chain outputs are high (inactive). Strobes idle high.
- R2: Narrow mode (`bus8_i`=0): capture number p writes `data_i[k]` to buffer bit 4p+k for k=0..3. `data_i[7:4]` has no effect.
- R3: Wide mode (`bus8_i`=1): capture number p writes `data_i[k]` to buffer bit 8p+k for k=0..7.
- R4: A line-strobe falling edge copies the buffer into the output register. The output register does not change at any other time.
- R5: With the display on, column j takes data bit b and phase m and produces code 00 (V0) when b equals m, and code 01 (V1) otherwise.
- R6: With `disp_on_i` low, every column shows code 10 (VM), whatever the data or phase.
- R7: With `rev_i`=0, column j (0-based, `seg_code_o[2j+1:2j]`) uses register bit j. With `rev_i`=1 it uses register bit 319-j.
- R8: A capture is ignored while the active chain input is high. The input side is `chain_a_in_n` when `rev_i`=0 and `chain_b_in_n` when `rev_i`=1.
- R9: The capture that fills the line drives the output-side chain pin low. The output side is `chain_b_out_n` when `rev_i`=0 and `chain_a_out_n` when `rev_i`=1. The other chain output stays high. A line-strobe edge raises it again.
- R10: Reduced mode (`full_mode_i`=0): the line is full after 240 bits (60 narrow or 30 wide captures). Buffer bits 0..239 move to register bits 40..279 and register bits outside that range become 0. Columns 0..39 and 280..319 always show the not-selected code, which is 01 when m=1 and 00 when m=0.
- R11: Captures after the line is full are ignored. When both strobes fall in the same cycle, the line strobe wins and the capture is dropped.
- R12: No column ever shows code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl1_i | input | 1 | Line strobe, falling edge transfers the line |
| cl2_i | input | 1 | Capture strobe, falling edge stores one bus word |
| m_i | input | 1 | AC drive phase |
| data_i | input | 8 | Parallel display data |
| bus8_i | input | 1 | 1 = 8-bit bus, 0 = 4-bit bus |
| full_mode_i | input | 1 | 1 = 320 columns, 0 = 240 columns |
| rev_i | input | 1 | 1 = mirrored column order and swapped chain sides |
| disp_on_i | input | 1 | 0 forces all columns to VM |
| chain_a_in_n | input | 1 | Chain token input, side A (low = capture) |
| chain_b_in_n | input | 1 | Chain token input, side B (low = capture) |
| chain_a_out_n | output | 1 | Chain token output, side A (low = full) |
| chain_b_out_n | output | 1 | Chain token output, side B (low = full) |
| seg_code_o | output | 640 | Two-bit level code per column, column j at bits 2j+1:2j |

## Verification
The hardest state to reach is the one where the line is full and a stray capture arrives in the same window as a line strobe or a mode change. The captured data only becomes visible after a later transfer, so every ignored capture must be followed by another line-strobe edge before its effect can be seen. The stimulus therefore fills complete lines in random widths, modes, orders and phases, adds zero to two surplus captures past the full point, blocks the token on both sides, and drops both strobes in the same cycle. Each case is followed by a transfer and a full comparison of all 320 column codes against a bench-side buffer model.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;
  typedef enum logic [1:0] {
    LVL_V0 = 2'b00,
    LVL_V1 = 2'b01,
    LVL_VM = 2'b10
  } lvl_e;
endpackage

// File: rtl/lcd_strobe_sync.sv
module lcd_strobe_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic fall_o
);
  // two synchronizer stages plus one history stage, idle level high
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= strobe_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q & ~s2_q;
endmodule

// File: rtl/lcd_capture_ctrl.sv
module lcd_capture_ctrl #(
  parameter int N_OUT       = 320,
  parameter int REDUCED_OUT = 240,
  parameter int BUS_W       = 8,
  parameter int NARROW_W    = 4,
  parameter int NPOS        = N_OUT / NARROW_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_fall_i,
  input  logic            cap_fall_i,
  input  logic            bus8_i,
  input  logic            full_mode_i,
  input  logic            en_in_n_i,
  output logic [NPOS-1:0] ptr_o,
  output logic            wr_o,
  output logic            full_o
);
  localparam int PW       = $clog2(NPOS);
  localparam int LAST_N_F = N_OUT / NARROW_W - 1;
  localparam int LAST_W_F = N_OUT / BUS_W - 1;
  localparam int LAST_N_R = REDUCED_OUT / NARROW_W - 1;
  localparam int LAST_W_R = REDUCED_OUT / BUS_W - 1;

  logic [NPOS-1:0] ptr_q;
  logic            full_q;
  logic [PW-1:0]   last_idx;

  always_comb begin
    unique case ({bus8_i, full_mode_i})
      2'b00:   last_idx = PW'(LAST_N_R);
      2'b01:   last_idx = PW'(LAST_N_F);
      2'b10:   last_idx = PW'(LAST_W_R);
      default: last_idx = PW'(LAST_W_F);
    endcase
  end

  // line strobe has priority over a coincident capture
  assign wr_o = cap_fall_i & ~line_fall_i & ~en_in_n_i & ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= NPOS'(1);
      full_q <= 1'b0;
    end else if (line_fall_i) begin
      ptr_q  <= NPOS'(1);
      full_q <= 1'b0;
    end else if (wr_o) begin
      ptr_q <= {ptr_q[NPOS-2:0], 1'b0};
      if (ptr_q[last_idx]) full_q <= 1'b1;
    end
  end

  assign ptr_o  = ptr_q;
  assign full_o = full_q;
endmodule

// File: rtl/lcd_line_buffer.sv
module lcd_line_buffer #(
  parameter int N_OUT       = 320,
  parameter int REDUCED_OUT = 240,
  parameter int BUS_W       = 8,
  parameter int NARROW_W    = 4,
  parameter int NPOS        = N_OUT / NARROW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic             bus8_i,
  input  logic             full_mode_i,
  input  logic [NPOS-1:0]  ptr_i,
  input  logic [BUS_W-1:0] data_i,
  input  logic             xfer_i,
  output logic [N_OUT-1:0] line_o
);
  localparam int EDGE = (N_OUT - REDUCED_OUT) / 2;

  logic [N_OUT-1:0] stage1_q;
  logic [N_OUT-1:0] stage2_q;
  logic [N_OUT-1:0] hit;
  logic [N_OUT-1:0] wbit;

  // per-bit slot select and lane select for both bus widths
  for (genvar b = 0; b < N_OUT; b++) begin : g_bit
    assign hit[b]  = bus8_i ? ptr_i[b / BUS_W] : ptr_i[b / NARROW_W];
    assign wbit[b] = bus8_i ? data_i[b % BUS_W] : data_i[b % NARROW_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
    end else if (wr_i) begin
      for (int b = 0; b < N_OUT; b++) begin
        if (hit[b]) stage1_q[b] <= wbit[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage2_q <= '0;
    end else if (xfer_i) begin
      if (full_mode_i) stage2_q <= stage1_q;
      else stage2_q <= {{EDGE{1'b0}}, stage1_q[REDUCED_OUT-1:0], {EDGE{1'b0}}};
    end
  end

  assign line_o = stage2_q;
endmodule

// File: rtl/lcd_level_encoder.sv
module lcd_level_encoder
  import lcd_seg_pkg::*;
#(
  parameter int N_OUT       = 320,
  parameter int REDUCED_OUT = 240
) (
  input  logic [N_OUT-1:0]   line_i,
  input  logic               m_i,
  input  logic               disp_on_i,
  input  logic               full_mode_i,
  input  logic               rev_i,
  output logic [2*N_OUT-1:0] code_o
);
  localparam int EDGE = (N_OUT - REDUCED_OUT) / 2;

  for (genvar j = 0; j < N_OUT; j++) begin : g_col
    localparam bit EDGE_COL = (j < EDGE) || (j >= N_OUT - EDGE);
    logic bit_w;
    lvl_e lvl;

    assign bit_w = rev_i ? line_i[N_OUT-1-j] : line_i[j];

    always_comb begin
      if (!disp_on_i)                  lvl = LVL_VM;
      else if (!full_mode_i && EDGE_COL) lvl = m_i ? LVL_V1 : LVL_V0;
      else if (bit_w == m_i)           lvl = LVL_V0;
      else                             lvl = LVL_V1;
    end

    assign code_o[2*j +: 2] = lvl;
  end
endmodule

// File: rtl/lcd_seg_line_drv.sv
module lcd_seg_line_drv #(
  parameter int N_OUT       = 320,
  parameter int REDUCED_OUT = 240,
  parameter int BUS_W       = 8,
  parameter int NARROW_W    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cl1_i,
  input  logic               cl2_i,
  input  logic               m_i,
  input  logic [BUS_W-1:0]   data_i,
  input  logic               bus8_i,
  input  logic               full_mode_i,
  input  logic               rev_i,
  input  logic               disp_on_i,
  input  logic               chain_a_in_n,
  input  logic               chain_b_in_n,
  output logic               chain_a_out_n,
  output logic               chain_b_out_n,
  output logic [2*N_OUT-1:0] seg_code_o
);
  localparam int NPOS = N_OUT / NARROW_W;

  logic            line_fall, cap_fall, wr, full, en_in_n;
  logic [NPOS-1:0] ptr;
  logic [N_OUT-1:0] line_q;

  lcd_strobe_sync u_line_sync (.clk(clk), .rst_n(rst_n), .strobe_i(cl1_i), .fall_o(line_fall));
  lcd_strobe_sync u_cap_sync  (.clk(clk), .rst_n(rst_n), .strobe_i(cl2_i), .fall_o(cap_fall));

  assign en_in_n = rev_i ? chain_b_in_n : chain_a_in_n;

  lcd_capture_ctrl #(
    .N_OUT(N_OUT), .REDUCED_OUT(REDUCED_OUT), .BUS_W(BUS_W), .NARROW_W(NARROW_W), .NPOS(NPOS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .line_fall_i(line_fall), .cap_fall_i(cap_fall),
    .bus8_i(bus8_i), .full_mode_i(full_mode_i), .en_in_n_i(en_in_n),
    .ptr_o(ptr), .wr_o(wr), .full_o(full)
  );

  lcd_line_buffer #(
    .N_OUT(N_OUT), .REDUCED_OUT(REDUCED_OUT), .BUS_W(BUS_W), .NARROW_W(NARROW_W), .NPOS(NPOS)
  ) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_i(wr), .bus8_i(bus8_i), .full_mode_i(full_mode_i),
    .ptr_i(ptr), .data_i(data_i), .xfer_i(line_fall), .line_o(line_q)
  );

  lcd_level_encoder #(.N_OUT(N_OUT), .REDUCED_OUT(REDUCED_OUT)) u_enc (
    .line_i(line_q), .m_i(m_i), .disp_on_i(disp_on_i), .full_mode_i(full_mode_i),
    .rev_i(rev_i), .code_o(seg_code_o)
  );

  // token leaves on the side opposite to where it enters
  assign chain_b_out_n = rev_i ? 1'b1 : ~full;
  assign chain_a_out_n = rev_i ? ~full : 1'b1;
endmodule

// File: rtl/lcd_seg_line_drv_chk.sv
module lcd_seg_line_drv_chk #(
  parameter int N_OUT = 320,
  parameter int NPOS  = 80
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*N_OUT-1:0] seg_code,
  input logic               disp_on,
  input logic               rev,
  input logic               a_out_n,
  input logic               b_out_n,
  input logic               en_in_n,
  input logic               line_fall,
  input logic [NPOS-1:0]    ptr,
  input logic [N_OUT-1:0]   line_q
);
  localparam logic [2*N_OUT-1:0] ALL_VM = {N_OUT{2'b10}};

  // R12
  always_comb begin
    if (rst_n === 1'b1) begin
      for (int j = 0; j < N_OUT; j++) begin
        no_bad_code_chk: assert (seg_code[2*j +: 2] != 2'b11);
      end
    end
  end

  // R6
  disp_off_vm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (seg_code == ALL_VM));

  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_fall |=> $stable(line_q));

  // R8
  blocked_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_in_n && !line_fall) |=> $stable(ptr));

  // R9
  idle_side_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rev |-> a_out_n);

  // R9
  idle_side_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev |-> b_out_n);

  // R9
  token_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_fall |=> (a_out_n && b_out_n));

  // R11
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr));
endmodule

bind lcd_seg_line_drv lcd_seg_line_drv_chk #(.N_OUT(N_OUT), .NPOS(NPOS)) u_chk (
  .clk(clk), .rst_n(rst_n), .seg_code(seg_code_o), .disp_on(disp_on_i), .rev(rev_i),
  .a_out_n(chain_a_out_n), .b_out_n(chain_b_out_n), .en_in_n(en_in_n),
  .line_fall(line_fall), .ptr(ptr), .line_q(line_q)
);

// File: tb/lcd_seg_line_drv_test.sv
module lcd_seg_line_drv_test;
  localparam int N = 320;

  logic clk = 1'b0;
  logic rst_n;
  logic cl1_i, cl2_i, m_i, bus8_i, full_mode_i, rev_i, disp_on_i;
  logic [7:0] data_i;
  logic chain_a_in_n, chain_b_in_n, chain_a_out_n, chain_b_out_n;
  logic [2*N-1:0] seg_code_o;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] mbuf, mreg;
  int           mptr;
  bit           mfull;

  always #10 clk = ~clk;

  lcd_seg_line_drv uut (
    .clk(clk), .rst_n(rst_n), .cl1_i(cl1_i), .cl2_i(cl2_i), .m_i(m_i), .data_i(data_i),
    .bus8_i(bus8_i), .full_mode_i(full_mode_i), .rev_i(rev_i), .disp_on_i(disp_on_i),
    .chain_a_in_n(chain_a_in_n), .chain_b_in_n(chain_b_in_n),
    .chain_a_out_n(chain_a_out_n), .chain_b_out_n(chain_b_out_n), .seg_code_o(seg_code_o)
  );

  function automatic int line_limit();
    int bits = full_mode_i ? 320 : 240;
    return bus8_i ? bits / 8 : bits / 4;
  endfunction

  function automatic logic [2*N-1:0] exp_codes();
    logic [2*N-1:0] v;
    for (int j = 0; j < N; j++) begin
      logic b;
      b = rev_i ? mreg[N-1-j] : mreg[j];
      if (!disp_on_i) v[2*j +: 2] = 2'b10;
      else if (!full_mode_i && (j < 40 || j >= 280)) v[2*j +: 2] = {1'b0, m_i};
      else v[2*j +: 2] = {1'b0, b ^ m_i};
    end
    return v;
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic chk_codes(string req);
    logic [2*N-1:0] e;
    e = exp_codes();
    checks++;
    if (seg_code_o !== e) begin
      fails++;
      $display("FAIL %s codes actual=%h expected=%h", req, seg_code_o, e);
    end
  endtask

  task automatic chk_chain(string req);
    logic ea, eb;
    ea = rev_i ? ~mfull : 1'b1;
    eb = rev_i ? 1'b1 : ~mfull;
    checks++;
    if (chain_a_out_n !== ea || chain_b_out_n !== eb) begin
      fails++;
      $display("FAIL %s chain actual=%b%b expected=%b%b", req, chain_a_out_n, chain_b_out_n, ea, eb);
    end
  endtask

  task automatic capture(logic [7:0] d);
    bit en_act;
    data_i = d;
    cl2_i  = 1'b0;
    en_act = rev_i ? !chain_b_in_n : !chain_a_in_n;
    if (en_act && !mfull) begin
      int w = bus8_i ? 8 : 4;
      for (int k = 0; k < w; k++) mbuf[mptr*w + k] = d[k];
      mptr++;
      if (mptr == line_limit()) mfull = 1'b1;
    end
    repeat (4) @(negedge clk);
    cl2_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic model_xfer();
    if (full_mode_i) mreg = mbuf;
    else begin
      mreg = '0;
      for (int i = 0; i < 240; i++) mreg[40+i] = mbuf[i];
    end
    mptr  = 0;
    mfull = 1'b0;
  endtask

  task automatic line_strobe();
    cl1_i = 1'b0;
    model_xfer();
    repeat (4) @(negedge clk);
    cl1_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic fill_line(int extra);
    int n = line_limit() + extra;
    for (int i = 0; i < n; i++) capture(8'($urandom));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cl1_i = 1'b1; cl2_i = 1'b1; m_i = 1'b0; data_i = '0;
    bus8_i = 1'b0; full_mode_i = 1'b1; rev_i = 1'b0; disp_on_i = 1'b1;
    chain_a_in_n = 1'b0; chain_b_in_n = 1'b0;
    mbuf = '0; mreg = '0; mptr = 0; mfull = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk_codes("R1");
    chk_chain("R1");

    // R2 directed narrow line with noisy upper nibble
    for (int i = 0; i < 80; i++) capture({4'hF, 4'(i)});
    chk_chain("R9");
    chk_codes("R4");
    line_strobe();
    chk_codes("R2");
    chk_chain("R9");

    // R3 wide line plus one surplus capture (R11)
    bus8_i = 1'b1;
    fill_line(1);
    line_strobe();
    chk_codes("R3");
    chk_codes("R11");

    // R10 reduced mode, reversed, phase high
    full_mode_i = 1'b0; rev_i = 1'b1; m_i = 1'b1; bus8_i = 1'b0;
    fill_line(0);
    chk_chain("R9");
    line_strobe();
    chk_codes("R10");

    // random lines covering R5, R7, R10, R11
    for (int it = 0; it < 10; it++) begin
      bus8_i      = 1'($urandom);
      full_mode_i = 1'($urandom);
      rev_i       = 1'($urandom);
      m_i         = 1'($urandom);
      fill_line($urandom % 3);
      chk_chain("R9");
      chk_codes("R4");
      line_strobe();
      if (!full_mode_i) chk_codes("R10");
      else if (rev_i) chk_codes("R7");
      else chk_codes("R5");
    end

    // R8 token blocked on both sides
    bus8_i = 1'b0; full_mode_i = 1'b1; rev_i = 1'b0;
    chain_a_in_n = 1'b1; chain_b_in_n = 1'b1;
    for (int i = 0; i < 12; i++) capture(8'($urandom));
    chk_chain("R8");
    line_strobe();
    chk_codes("R8");
    chain_a_in_n = 1'b0; chain_b_in_n = 1'b0;

    // R9 partial line keeps token inactive
    rev_i = 1'b1;
    for (int i = 0; i < 5; i++) capture(8'($urandom));
    chk_chain("R9");
    line_strobe();
    chk_codes("R7");

    // R11 coincident strobes: capture dropped
    data_i = 8'hA5;
    cl1_i = 1'b0; cl2_i = 1'b0;
    model_xfer();
    repeat (4) @(negedge clk);
    cl1_i = 1'b1; cl2_i = 1'b1;
    repeat (4) @(negedge clk);
    chk_codes("R11");
    line_strobe();
    chk_codes("R11");

    // R5 phase flip without transfer
    m_i = ~m_i;
    @(negedge clk);
    chk_codes("R5");

    // R6 display off, then back on
    disp_on_i = 1'b0;
    @(negedge clk);
    chk_codes("R6");
    disp_on_i = 1'b1;
    @(negedge clk);
    chk_codes("R12");

    summary();
    $finish;
  end
endmodule